// File: doc/BRIEF.md
# LCD AC-Drive Polarity Pulse Generator

This block produces the vertical-side timing pulses for an LCD panel that is driven with alternating polarity. It keeps a dot counter inside each horizontal line and a line counter inside each field. Both counters are referenced to the rising edges of the incoming horizontal and vertical sync. From these two counts it derives several outputs:
- a vertical shift clock
- a polarity-inversion pulse
- a one-line vertical start pulse
- a complementary pair of horizontal clocks, whose phase follows the horizontal scan direction

It also passes scan-direction and blanking control bits to the panel.

Software programs the block through a small write-only register port. All writes land in a shadow copy. The shadow copy is transferred to the working copy only on a vertical sync rising edge, so a field never mixes old and new settings. The settings are:
- the inversion position within the line, in 2-dot steps
- the vertical picture position
- the line length
- the inversion cycle, per line or per field
- the scan directions
- the three panel control bits

Top module: `lcd_pol_pulse_gen`

## Requirements
- R1: After reset: scan_rl_o=1, scan_ud_o=0, hb_o=vb1_o=vb2_o=1, blk_o=0, vck_o=0, frp_o=0. The working settings are inversion position 0x086, vertical position 0x020, line length 1716, and line-inversion mode.
- R2: Register port, with cfg_addr_i selecting the register:
  - 0: inversion position, cfg_wdata_i[11:0]
  - 1: vertical position, cfg_wdata_i[10:0]
  - 2: line length, cfg_wdata_i[11:0]
  - 3: mode. Bit 0 selects field inversion, bit 1 is the horizontal direction, bit 2 is the vertical direction.
  - 4: panel. Bit 0 is hb, bit 1 is vb1, bit 2 is vb2.

  A write changes no output until the next vsync_i rising edge. From that edge on, the new value is in force.
- R3: The dot counter is cleared to 0 by the clock edge that first samples hsync_i high. It increments on every later clock and wraps to 0 after reaching line length minus 1.
- R4: The line counter is cleared to 0 by the clock edge that first samples vsync_i high. It increments by one on each hsync_i rising edge.
- R5: vck_o toggles one clock after the dot counter equals the inversion position with bit 0 cleared. This happens only on lines whose count is at least the vertical position. The vsync_i rising edge forces vck_o to 0.
- R6: In line-inversion mode (mode bit 0 = 0), frp_o toggles at the same point as vck_o on every line whose count is at least the vertical position. It is never cleared by vsync_i.
- R7: In field-inversion mode (mode bit 0 = 1), frp_o toggles only on the line whose count equals the vertical position, once per field.
- R8: vst_o is high exactly while the line count equals the vertical position.
- R9: hck1_o equals dot counter bit 0 when the horizontal direction is 1, and its inverse when it is 0. hck2_o is always the complement of hck1_o.
- R10: scan_rl_o and scan_ud_o follow the horizontal and vertical direction bits. hb_o, vb1_o and vb2_o follow the panel bits. blk_o is high when vb1 or vb2 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, rising edge starts a line |
| vsync_i | input | 1 | Vertical sync, rising edge starts a field and applies settings |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 12 | Register write data |
| vck_o | output | 1 | Vertical shift clock |
| frp_o | output | 1 | Polarity inversion pulse |
| vst_o | output | 1 | Vertical start pulse, one line wide |
| hck1_o | output | 1 | Horizontal clock, phase A |
| hck2_o | output | 1 | Horizontal clock, phase B |
| scan_rl_o | output | 1 | Horizontal scan direction |
| scan_ud_o | output | 1 | Vertical scan direction |
| hb_o | output | 1 | Panel control bit hb |
| vb1_o | output | 1 | Panel control bit vb1 |
| vb2_o | output | 1 | Panel control bit vb2 |
| blk_o | output | 1 | Blanking pulse |

## Verification
The hardest situation to reach from the ports is the dot counter wrapping on its own, without hsync. This is the only way the line-length setting becomes visible, and at the default length it takes more than 1700 clocks. The bench therefore programs a short line length, sends a single hsync, and then withholds hsync long enough to see several wrap-induced toggles. The field-mode single toggle is reached by randomising the vertical position near the top of the field and running a few lines past it. Deferred register application is exposed by writing fresh random settings and sampling the outputs before and after the vsync that applies them.

// File: rtl/lpg_pkg.sv
// Package: shared widths, register addresses and the settings record
// used by the LCD polarity pulse generator.
package lpg_pkg;

    localparam int DOT_W  = 12;   // dot counter and horizontal settings
    localparam int LINE_W = 11;   // line counter and vertical position
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_INVPOS  = 3'd0,
        ADDR_VPOS    = 3'd1,
        ADDR_LINELEN = 3'd2,
        ADDR_MODE    = 3'd3,
        ADDR_PANEL   = 3'd4
    } lpg_addr_e;

    typedef struct packed {
        logic [DOT_W-1:0]  inv_pos;
        logic [LINE_W-1:0] vpos;
        logic [DOT_W-1:0]  line_len;
        logic              field_mode;
        logic              hdir;
        logic              vdir;
        logic              hb;
        logic              vb1;
        logic              vb2;
    } lpg_cfg_t;

endpackage

// File: rtl/lpg_cfg_regs.sv
// Settings store with a shadow and a working copy.
// Writes update the shadow copy; the working copy takes the whole shadow
// on load_i (vsync rising edge). Assumes load_i is a one-clock strobe.
module lpg_cfg_regs
    import lpg_pkg::*;
#(
    parameter logic [DOT_W-1:0]  INV_POS_RST  = 12'h086,
    parameter logic [LINE_W-1:0] VPOS_RST     = 11'h020,
    parameter logic [DOT_W-1:0]  LINE_LEN_RST = 12'd1716
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DOT_W-1:0]  wdata_i,
    input  logic              load_i,
    output lpg_cfg_t          cfg_o
);

    localparam lpg_cfg_t RST_CFG = '{
        inv_pos:    INV_POS_RST,
        vpos:       VPOS_RST,
        line_len:   LINE_LEN_RST,
        field_mode: 1'b0,
        hdir:       1'b1,
        vdir:       1'b0,
        hb:         1'b1,
        vb1:        1'b1,
        vb2:        1'b1
    };

    lpg_cfg_t shd_q;
    lpg_cfg_t act_q;

    // Shadow copy: capture register writes by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= RST_CFG;
        end else if (we_i) begin
            case (addr_i)
                ADDR_INVPOS:  shd_q.inv_pos  <= wdata_i;
                ADDR_VPOS:    shd_q.vpos     <= wdata_i[LINE_W-1:0];
                ADDR_LINELEN: shd_q.line_len <= wdata_i;
                ADDR_MODE: begin
                    shd_q.field_mode <= wdata_i[0];
                    shd_q.hdir       <= wdata_i[1];
                    shd_q.vdir       <= wdata_i[2];
                end
                ADDR_PANEL: begin
                    shd_q.hb  <= wdata_i[0];
                    shd_q.vb1 <= wdata_i[1];
                    shd_q.vb2 <= wdata_i[2];
                end
                default: ;
            endcase
        end
    end

    // Working copy: transfer the shadow only at the field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= RST_CFG;
        end else if (load_i) begin
            act_q <= shd_q;
        end
    end

    assign cfg_o = act_q;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_q)); // R2
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (act_q == $past(shd_q))); // R2

endmodule

// File: rtl/lpg_timing_counters.sv
// Sync edge detection plus dot and line counters.
// Dot counter: cleared on the hsync rising edge, else increments and wraps
// after line_len_i-1. Line counter: cleared on the vsync rising edge,
// incremented on each hsync rising edge, saturating at all ones.
// Assumes hsync_i and vsync_i are already synchronous to clk.
module lpg_timing_counters
    import lpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [DOT_W-1:0]  line_len_i,
    output logic              vs_rise_o,
    output logic [DOT_W-1:0]  dot_cnt_o,
    output logic [LINE_W-1:0] line_cnt_o
);

    localparam logic [DOT_W-1:0]  DOT_ONE  = DOT_W'(1);
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    logic              hs_q;
    logic              vs_q;
    logic              hs_rise;
    logic              vs_rise;
    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q;
    logic              dot_last;

    // Previous sync levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync_i;
            vs_q <= vsync_i;
        end
    end

    assign hs_rise  = hsync_i & ~hs_q;
    assign vs_rise  = vsync_i & ~vs_q;
    assign dot_last = (dot_q == (line_len_i - DOT_ONE));

    // Dot position within the current line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_q <= '0;
        end else if (hs_rise) begin
            dot_q <= '0;
        end else if (dot_last) begin
            dot_q <= '0;
        end else begin
            dot_q <= dot_q + DOT_ONE;
        end
    end

    // Line position within the current field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (vs_rise) begin
            line_q <= '0;
        end else if (hs_rise && (line_q != LINE_MAX)) begin
            line_q <= line_q + LINE_ONE;
        end
    end

    assign vs_rise_o  = vs_rise;
    assign dot_cnt_o  = dot_q;
    assign line_cnt_o = line_q;

    AST_DOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> (dot_q == '0)); // R3
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> (line_q == '0)); // R4
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_rise && !hs_rise) |=> $stable(line_q)); // R4

endmodule

// File: rtl/lpg_pulse_gen.sv
// Pulse generation from the dot and line counts.
// VCK and FRP flip one clock after the dot count reaches the inversion
// position with bit 0 cleared. VCK acts on lines at or past the vertical
// position and is cleared by vsync. FRP either follows every such line or
// only the line at the vertical position. VST and the horizontal clock
// pair are decoded from the counters.
// Assumes the settings are stable within a field.
module lpg_pulse_gen
    import lpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_rise_i,
    input  logic [DOT_W-1:0]  dot_cnt_i,
    input  logic [LINE_W-1:0] line_cnt_i,
    input  logic [DOT_W-1:0]  inv_pos_i,
    input  logic [LINE_W-1:0] vpos_i,
    input  logic              field_mode_i,
    input  logic              hdir_i,
    output logic              vck_o,
    output logic              frp_o,
    output logic              vst_o,
    output logic              hck1_o,
    output logic              hck2_o
);

    logic [DOT_W-1:0] inv_even;
    logic             unused_inv_lsb;
    logic             tog_evt;
    logic             in_active;
    logic             at_vpos;
    logic             frp_en;
    logic             vck_q;
    logic             frp_q;
    logic             hck_a;

    assign inv_even       = {inv_pos_i[DOT_W-1:1], 1'b0};
    assign unused_inv_lsb = inv_pos_i[0];

    // Decode of the toggle point and of the line window.
    always_comb begin
        tog_evt   = (dot_cnt_i == inv_even);
        in_active = (line_cnt_i >= vpos_i);
        at_vpos   = (line_cnt_i == vpos_i);
        frp_en    = field_mode_i ? at_vpos : in_active;
    end

    // Vertical clock: flip at the toggle point, cleared at field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vck_q <= 1'b0;
        end else if (vs_rise_i) begin
            vck_q <= 1'b0;
        end else if (tog_evt && in_active) begin
            vck_q <= ~vck_q;
        end
    end

    // Polarity pulse: flip per line or per field, never cleared by sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frp_q <= 1'b0;
        end else if (tog_evt && frp_en) begin
            frp_q <= ~frp_q;
        end
    end

    // Horizontal clock pair, phase chosen by scan direction.
    always_comb begin
        hck_a = dot_cnt_i[0] ^ ~hdir_i;
    end

    assign vck_o  = vck_q;
    assign frp_o  = frp_q;
    assign vst_o  = at_vpos;
    assign hck1_o = hck_a;
    assign hck2_o = ~hck_a;

    AST_VCK_AT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vck_q) |-> $past(tog_evt || vs_rise_i)); // R5
    AST_FRP_EVEN_DOT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frp_q) |-> ($past(dot_cnt_i[0]) == 1'b0)); // R6
    AST_FRP_FIELD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(frp_q) && $past(field_mode_i)) |-> $past(line_cnt_i == vpos_i)); // R7

endmodule

// File: rtl/lcd_pol_pulse_gen.sv
// Top level of the LCD AC-drive polarity pulse generator.
// Connects the settings store, the sync counters and the pulse decoder,
// and drives the direction and panel control pins from the working
// settings. Assumes synchronous sync inputs and a single clock domain.
module lcd_pol_pulse_gen
    import lpg_pkg::*;
#(
    parameter logic [DOT_W-1:0]  INV_POS_RST  = 12'h086,
    parameter logic [LINE_W-1:0] VPOS_RST     = 11'h020,
    parameter logic [DOT_W-1:0]  LINE_LEN_RST = 12'd1716
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DOT_W-1:0]  cfg_wdata_i,
    output logic              vck_o,
    output logic              frp_o,
    output logic              vst_o,
    output logic              hck1_o,
    output logic              hck2_o,
    output logic              scan_rl_o,
    output logic              scan_ud_o,
    output logic              hb_o,
    output logic              vb1_o,
    output logic              vb2_o,
    output logic              blk_o
);

    lpg_cfg_t          cfg;
    logic              vs_rise;
    logic [DOT_W-1:0]  dot_cnt;
    logic [LINE_W-1:0] line_cnt;

    lpg_cfg_regs #(
        .INV_POS_RST  (INV_POS_RST),
        .VPOS_RST     (VPOS_RST),
        .LINE_LEN_RST (LINE_LEN_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .load_i  (vs_rise),
        .cfg_o   (cfg)
    );

    lpg_timing_counters u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_i    (hsync_i),
        .vsync_i    (vsync_i),
        .line_len_i (cfg.line_len),
        .vs_rise_o  (vs_rise),
        .dot_cnt_o  (dot_cnt),
        .line_cnt_o (line_cnt)
    );

    lpg_pulse_gen u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .vs_rise_i    (vs_rise),
        .dot_cnt_i    (dot_cnt),
        .line_cnt_i   (line_cnt),
        .inv_pos_i    (cfg.inv_pos),
        .vpos_i       (cfg.vpos),
        .field_mode_i (cfg.field_mode),
        .hdir_i       (cfg.hdir),
        .vck_o        (vck_o),
        .frp_o        (frp_o),
        .vst_o        (vst_o),
        .hck1_o       (hck1_o),
        .hck2_o       (hck2_o)
    );

    // Direction and panel control pins from the working settings.
    always_comb begin
        scan_rl_o = cfg.hdir;
        scan_ud_o = cfg.vdir;
        hb_o      = cfg.hb;
        vb1_o     = cfg.vb1;
        vb2_o     = cfg.vb2;
        blk_o     = ~(cfg.vb1 & cfg.vb2);
    end

    AST_PANEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> ($stable(scan_rl_o) && $stable(scan_ud_o) && $stable(blk_o))); // R10
    AST_HCK_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hck1_o != hck2_o)); // R9

endmodule

// File: tb/lcd_pol_pulse_gen_tb.sv
module lcd_pol_pulse_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_i = 1'b0;
    logic        vsync_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_addr_i = '0;
    logic [11:0] cfg_wdata_i = '0;
    logic vck_o, frp_o, vst_o, hck1_o, hck2_o;
    logic scan_rl_o, scan_ud_o, hb_o, vb1_o, vb2_o, blk_o;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lcd_pol_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .vck_o(vck_o), .frp_o(frp_o), .vst_o(vst_o), .hck1_o(hck1_o),
        .hck2_o(hck2_o), .scan_rl_o(scan_rl_o), .scan_ud_o(scan_ud_o),
        .hb_o(hb_o), .vb1_o(vb1_o), .vb2_o(vb2_o), .blk_o(blk_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected cycle count, from the sampling edge of hsync, at which VCK flips.
    function automatic int tog_count(input int pos);
        return (pos & ~1) + 2;
    endfunction

    function automatic int hck1_even(input bit hdir);
        return hdir ? 0 : 1;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic vsync_pulse();
        @(negedge clk);
        vsync_i = 1'b1;
        @(negedge clk);
        vsync_i = 1'b0;
    endtask

    // One line of P clocks; counts VCK/FRP flips and samples VST and HCK.
    task automatic run_line(input int P, input int pos, input int exp_vck,
                            input int exp_frp, input int exp_vst, input bit hdir);
        int nv = 0, nf = 0, first = -1;
        logic pv, pf;
        @(negedge clk);
        pv = vck_o; pf = frp_o;
        hsync_i = 1'b1;
        for (int c = 1; c <= P; c++) begin
            @(negedge clk);
            if (c == 1) begin
                hsync_i = 1'b0;
                check("R8 vst in line", int'(vst_o), exp_vst);
            end
            if (c == 3) begin
                check("R9 hck1 phase", int'(hck1_o), hck1_even(hdir));
                check("R9 hck2 complement", int'(hck2_o), 1 - hck1_even(hdir));
            end
            if (vck_o != pv) begin nv++; if (first < 0) first = c; end
            if (frp_o != pf) nf++;
            pv = vck_o; pf = frp_o;
        end
        check("R5 vck toggles per line", nv, exp_vck);
        if (exp_vck == 1) check("R5 vck toggle position", first, tog_count(pos));
        check("R6/R7 frp toggles per line", nf, exp_frp);
    endtask

    task automatic run_field(input int P, input int L, input int vp, input int pos,
                             input bit field, input bit hdir);
        for (int k = 1; k <= L; k++) begin
            int ef;
            ef = field ? int'(k == vp) : int'(k >= vp);
            run_line(P, pos, int'(k >= vp), ef, int'(k == vp), hdir);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 scan_rl", int'(scan_rl_o), 1);
        check("R1 scan_ud", int'(scan_ud_o), 0);
        check("R1 hb", int'(hb_o), 1);
        check("R1 vb1", int'(vb1_o), 1);
        check("R1 vb2", int'(vb2_o), 1);
        check("R1 blk", int'(blk_o), 0);
        check("R1 vck", int'(vck_o), 0);
        check("R1 frp", int'(frp_o), 0);

        // R1 default settings: position 0x086, vertical position 32, line mode
        vsync_pulse();
        check("R5 vck cleared by vsync", int'(vck_o), 0);
        run_field(160, 34, 32, 12'h086, 1'b0, 1'b1);

        // R3 line length wrap without hsync; R4 line count cleared by vsync
        wr(3'd2, 12'd40);
        wr(3'd0, 12'd11);
        wr(3'd1, 12'd0);
        vsync_pulse();
        check("R4 line 0 after vsync (vst with vpos 0)", int'(vst_o), 1);
        begin
            int nv = 0, first = -1;
            logic pv;
            @(negedge clk);
            pv = vck_o;
            hsync_i = 1'b1;
            for (int c = 1; c <= 120; c++) begin
                @(negedge clk);
                if (c == 1) begin
                    hsync_i = 1'b0;
                    check("R4 line increments on hsync", int'(vst_o), 0);
                end
                if (vck_o != pv) begin nv++; if (first < 0) first = c; end
                pv = vck_o;
            end
            check("R3 wrap toggles in 120 clocks", nv, 3);
            check("R3 first toggle (odd position rounds down)", first, 12);
        end
        wr(3'd2, 12'd1716);

        // Random fields: deferred settings, both inversion modes, directions
        for (int f = 0; f < 24; f++) begin
            int pos, vp;
            bit fm, hd, vd, b0, b1, b2;
            int o_rl, o_ud, o_hb, o_blk;
            pos = int'($urandom_range(0, 54));
            vp  = int'($urandom_range(0, 4));
            fm = 1'($urandom); hd = 1'($urandom); vd = 1'($urandom);
            b0 = 1'($urandom); b1 = 1'($urandom); b2 = 1'($urandom);
            if (f == 0) begin fm = 1'b1; b1 = 1'b0; end
            if (f == 1) begin fm = 1'b0; hd = 1'b0; end
            o_rl = int'(scan_rl_o); o_ud = int'(scan_ud_o);
            o_hb = int'(hb_o); o_blk = int'(blk_o);
            wr(3'd0, 12'(pos));
            wr(3'd1, 12'(vp));
            wr(3'd3, {9'd0, vd, hd, fm});
            wr(3'd4, {9'd0, b2, b1, b0});
            check("R2 scan_rl held before vsync", int'(scan_rl_o), o_rl);
            check("R2 scan_ud held before vsync", int'(scan_ud_o), o_ud);
            check("R2 hb held before vsync", int'(hb_o), o_hb);
            check("R2 blk held before vsync", int'(blk_o), o_blk);
            vsync_pulse();
            check("R10 scan_rl", int'(scan_rl_o), int'(hd));
            check("R10 scan_ud", int'(scan_ud_o), int'(vd));
            check("R10 hb", int'(hb_o), int'(b0));
            check("R10 vb1", int'(vb1_o), int'(b1));
            check("R10 vb2", int'(vb2_o), int'(b2));
            check("R10 blk", int'(blk_o), int'(!(b1 && b2)));
            check("R5 vck cleared by vsync", int'(vck_o), 0);
            run_field(64, vp + 3, vp, pos, fm, hd);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
            $finish;
        end
    end

endmodule